// File: doc/BRIEF.md
# Protected Page Translation Cache

A small fully associative cache of page translations. Each lookup presents a virtual address, whether the access is a write, and whether it comes from user mode. Every stored tag is compared with the virtual page number at the same time. On a hit, the block returns a physical address made of the stored physical page number and the unchanged page offset. If a matching entry forbids the access, the block raises a protection fault in place of the hit.

Each entry carries five flags: valid, dirty, referenced, kernel-only and writable. A permitted access marks its entry as referenced. A permitted write also marks it dirty. Both flags of the matched entry are visible on the lookup port, so outside logic can copy them to the page table.

An external walker fills entries through a refill port after a miss. The refill goes to the lowest-numbered free slot. When no slot is free, a round-robin pointer picks the slot. If the displaced entry was dirty, the block emits a one-cycle notification that carries its virtual page number. Two commands act on the whole table in one cycle: one clears every referenced flag, and one invalidates every entry.

Top module: `tlb_prot`

## Requirements
- R1: On a permitted hit, `lk_paddr` equals the matched entry's physical page number in bits [31:12] joined with `lk_vaddr[11:0]`, in the same cycle as the lookup.
- R2: A refilled translation is found by a later lookup no matter which of the 16 slots holds it. At most one slot matches a given page number.
- R3: A lookup that matches no valid entry, or no lookup at all, gives `lk_hit`=0, `lk_fault`=0, and `lk_paddr` with a zero page number, `lk_refd`=0 and `lk_dirty`=0.
- R4: A permitted access sets the entry's referenced flag. `lk_refd` shows the flag as stored before the current access.
- R5: A permitted write sets the entry's dirty flag. `lk_dirty` shows the flag as stored before the current access.
- R6: A user-mode access (`lk_user`=1) to a kernel-only entry gives `lk_fault`=1 and `lk_hit`=0, and leaves the entry's flags unchanged.
- R7: A write to an entry whose writable flag is 0 gives `lk_fault`=1 and `lk_hit`=0, and leaves the flags unchanged.
- R8: `ref_clear` zeroes the referenced flag of every entry at the next edge.
- R9: A refill writes the lowest-numbered invalid slot and starts the entry with dirty=0 and referenced=0.
- R10: When every slot is valid, a refill replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and moves up by one, wrapping, after each such refill.
- R11: When a refill replaces a valid dirty entry, `wb_valid` is 1 for exactly the next cycle and `wb_vpn` holds the replaced page number. Otherwise `wb_valid` stays 0.
- R12: `flush` invalidates all entries at the next edge. A refill in the same cycle is dropped.
- R13: Same-cycle ordering: a lookup sees the table as it stood before the edge, so it cannot hit a translation being refilled in that cycle, and `ref_clear` overrides a referenced flag set by a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Permitted hit |
| lk_fault | output | 1 | Match found but access forbidden |
| lk_paddr | output | 32 | Translated address |
| lk_refd | output | 1 | Referenced flag of matched entry before this access |
| lk_dirty | output | 1 | Dirty flag of matched entry before this access |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_kern | input | 1 | Refill entry is kernel-only |
| rf_wr | input | 1 | Refill entry is writable |
| ref_clear | input | 1 | Clear all referenced flags |
| flush | input | 1 | Invalidate all entries |
| wb_valid | output | 1 | Dirty eviction notification |
| wb_vpn | output | 20 | Page number of the evicted dirty entry |

## Verification
The assertions assume that the refill port never loads a page number that is already held in a valid slot. This is what keeps the match vector one-hot. Before each refill, the stimulus looks in the bench's own model of the table and turns a refill of a resident page into a plain lookup. The dirty-flag assertion also takes for granted that no refill or flush lands in the same cycle as the write it follows, so it is disabled when one does. The random phase draws page numbers from a pool larger than the table. This forces round-robin evictions of dirty entries, flushes and flag clears to interleave with lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_BITS = 12;
    parameter int PPN_W     = 20;
    parameter int ENTRIES   = 16;

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PA_W  = PPN_W + PAGE_BITS;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             refd;
        logic             kern_only;
        logic             writable;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    // index of the lowest set bit, zero when none is set
    function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
        lowest_set = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (v[i]) lowest_set = IDX_W'(i);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [VPN_W-1:0]              vpn,
    input  tlb_entry_t [ENTRIES-1:0]      tbl,
    output logic [ENTRIES-1:0]            match_vec,
    output logic                          hit_any,
    output logic [IDX_W-1:0]              hit_idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = tbl[g].valid && (tbl[g].vpn == vpn);
    end

    assign hit_any = |match_vec;
    assign hit_idx = lowest_set(match_vec);

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec)); // R2
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] rr_ptr;
    logic             full;

    assign full       = &valid_vec;
    assign victim_idx = full ? rr_ptr : lowest_set(~valid_vec);

    always_ff @(posedge clk) begin
        if (rst)
            rr_ptr <= '0;
        else if (take && full)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end

    AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
        (take && full) |=> (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1))); // R10
    AST_RR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(take && full) |=> $stable(rr_ptr)); // R10
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_refd,
    output logic              lk_dirty,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_kern,
    input  logic              rf_wr,
    input  logic              ref_clear,
    input  logic              flush,
    output logic              wb_valid,
    output logic [VPN_W-1:0]  wb_vpn
);
    tlb_entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]       match_vec, valid_vec, refd_vec;
    logic                     hit_any, prot_bad, matched, take;
    logic [IDX_W-1:0]         hit_idx, victim_idx;
    tlb_entry_t               sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign valid_vec[g] = tbl[g].valid;
        assign refd_vec[g]  = tbl[g].refd;
    end

    tlb_match u_match (
        .clk(clk), .rst(rst), .vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .tbl(tbl),
        .match_vec(match_vec), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    assign take = rf_valid && !flush;

    tlb_victim u_victim (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .take(take),
        .victim_idx(victim_idx)
    );

    always_comb begin
        sel      = tbl[hit_idx];
        matched  = lk_valid && hit_any;
        prot_bad = (sel.kern_only && lk_user) || (lk_write && !sel.writable);
        lk_hit   = matched && !prot_bad;
        lk_fault = matched && prot_bad;
        lk_paddr = {(lk_hit ? sel.ppn : '0), lk_vaddr[PAGE_BITS-1:0]};
        lk_refd  = matched && sel.refd;
        lk_dirty = matched && sel.dirty;
    end

    // order inside the edge: access flags, bulk clear, refill, flush
    always_ff @(posedge clk) begin
        if (rst) begin
            tbl      <= '0;
            wb_valid <= 1'b0;
            wb_vpn   <= '0;
        end else begin
            wb_valid <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (lk_hit && (hit_idx == IDX_W'(i))) begin
                    tbl[i].refd <= 1'b1;
                    if (lk_write) tbl[i].dirty <= 1'b1;
                end
                if (ref_clear) tbl[i].refd <= 1'b0;
            end
            if (take) begin
                wb_valid        <= tbl[victim_idx].valid && tbl[victim_idx].dirty;
                wb_vpn          <= tbl[victim_idx].vpn;
                tbl[victim_idx] <= '{valid: 1'b1, dirty: 1'b0, refd: 1'b0,
                                     kern_only: rf_kern, writable: rf_wr,
                                     vpn: rf_vpn, ppn: rf_ppn};
            end
            if (flush)
                for (int i = 0; i < ENTRIES; i++) tbl[i].valid <= 1'b0;
        end
    end

    AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_fault)); // R6
    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_write && !rf_valid && !flush) |=> tbl[$past(hit_idx)].dirty); // R5
    AST_REF_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !rf_valid && !flush && !ref_clear) |=> tbl[$past(hit_idx)].refd); // R4
    AST_REF_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        ref_clear |=> (refd_vec == '0)); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)); // R12
    AST_WB_AFTER_REFILL: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(rf_valid && !flush)); // R11
endmodule

// File: tb/tlb_prot_tb.sv
module tlb_prot_tb;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic              lk_hit, lk_fault, lk_refd, lk_dirty;
    logic [PA_W-1:0]   lk_paddr;
    logic              rf_valid = 0, rf_kern = 0, rf_wr = 0, ref_clear = 0, flush = 0;
    logic [VPN_W-1:0]  rf_vpn = '0;
    logic [PPN_W-1:0]  rf_ppn = '0;
    logic              wb_valid;
    logic [VPN_W-1:0]  wb_vpn;

    tlb_prot u_dut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural model
    bit               mv[ENTRIES], md[ENTRIES], mr[ENTRIES], mk[ENTRIES], mw[ENTRIES];
    logic [VPN_W-1:0] mvpn[ENTRIES];
    logic [PPN_W-1:0] mppn[ENTRIES];
    int               rr = 0;

    // sampled outputs of the last cycle
    bit               s_hit, s_fault, s_refd, s_dirty, s_wb;
    logic [PA_W-1:0]  s_paddr;
    logic [VPN_W-1:0] s_wbvpn;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit resident(input logic [VPN_W-1:0] v);
        for (int i = 0; i < ENTRIES; i++) if (mv[i] && mvpn[i] == v) return 1;
        return 0;
    endfunction

    task automatic cyc(input bit lv, input logic [VPN_W-1:0] vpn, input logic [PAGE_BITS-1:0] off,
                       input bit wr, input bit usr, input bit rfv, input logic [VPN_W-1:0] rvpn,
                       input logic [PPN_W-1:0] rppn, input bit rk, input bit rw,
                       input bit fl, input bit rc);
        int m, vic;
        bit eh, ef, ewb, full;
        logic [PA_W-1:0] ep;
        logic [VPN_W-1:0] ewv;
        lk_valid = lv; lk_vaddr = {vpn, off}; lk_write = wr; lk_user = usr;
        rf_valid = rfv; rf_vpn = rvpn; rf_ppn = rppn; rf_kern = rk; rf_wr = rw;
        flush = fl; ref_clear = rc;
        #1;
        m = -1;
        for (int i = 0; i < ENTRIES; i++) if (mv[i] && mvpn[i] == vpn) m = i;
        eh = 0; ef = 0;
        if (lv && m >= 0) begin
            if ((mk[m] && usr) || (wr && !mw[m])) ef = 1; else eh = 1;
        end
        ep = {(eh ? mppn[m] : {PPN_W{1'b0}}), off};
        s_hit = lk_hit; s_fault = lk_fault; s_paddr = lk_paddr; s_refd = lk_refd; s_dirty = lk_dirty;
        chk(lk_hit == eh, "R2 hit", lk_hit, eh);
        chk(lk_fault == ef, "R6 fault", lk_fault, ef);
        chk(lk_paddr == ep, "R1 paddr", lk_paddr, ep);
        chk(lk_refd == ((eh || ef) && mr[m]), "R4 refd", lk_refd, (eh || ef) && mr[m]);
        chk(lk_dirty == ((eh || ef) && md[m]), "R5 dirty", lk_dirty, (eh || ef) && md[m]);
        // victim and notification from state before the edge
        ewb = 0; ewv = '0; vic = -1; full = 1;
        for (int i = ENTRIES - 1; i >= 0; i--) if (!mv[i]) begin vic = i; full = 0; end
        if (full) vic = rr;
        if (rfv && !fl) begin ewb = mv[vic] && md[vic]; ewv = mvpn[vic]; end
        if (eh) begin mr[m] = 1; if (wr) md[m] = 1; end
        if (rc) for (int i = 0; i < ENTRIES; i++) mr[i] = 0;
        if (rfv && !fl) begin
            mv[vic] = 1; md[vic] = 0; mr[vic] = 0; mk[vic] = rk; mw[vic] = rw;
            mvpn[vic] = rvpn; mppn[vic] = rppn;
            if (full) rr = (rr + 1) % ENTRIES;
        end
        if (fl) for (int i = 0; i < ENTRIES; i++) mv[i] = 0;
        @(posedge clk);
        @(negedge clk);
        s_wb = wb_valid; s_wbvpn = wb_vpn;
        chk(wb_valid == ewb, "R11 wb_valid", wb_valid, ewb);
        if (ewb) chk(wb_vpn == ewv, "R11 wb_vpn", wb_vpn, ewv);
        lk_valid = 0; rf_valid = 0; flush = 0; ref_clear = 0;
    endtask

    task automatic look(input logic [VPN_W-1:0] vpn, input bit wr, input bit usr);
        cyc(1, vpn, 12'h3a5, wr, usr, 0, '0, '0, 0, 0, 0, 0);
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn, input bit k, input bit w);
        cyc(0, '0, '0, 0, 0, 1, vpn, ppn, k, w, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: no hit, no notification
        chk(lk_hit == 0 && lk_fault == 0 && wb_valid == 0, "R3 reset", lk_hit, 0);
        rst = 0;
        look(20'h00aaa, 0, 1);
        chk(!s_hit && !s_fault && s_paddr[PA_W-1:PAGE_BITS] == 0, "R3 empty miss", s_hit, 0);

        fill(20'h00a01, 20'h11111, 0, 1);   // slot 0 user rw
        fill(20'h00a02, 20'h22222, 1, 1);   // slot 1 kernel rw
        fill(20'h00a03, 20'h33333, 0, 0);   // slot 2 user ro
        fill(20'h00a04, 20'h44444, 0, 1);   // slot 3 user rw

        look(20'h00a01, 0, 1);
        chk(s_hit && s_paddr == {20'h11111, 12'h3a5}, "R1 translate", s_paddr, {20'h11111, 12'h3a5});
        chk(s_refd == 0, "R4 fresh ref", s_refd, 0);
        look(20'h00a01, 1, 1);
        chk(s_refd == 1 && s_dirty == 0, "R4 ref after read", s_refd, 1);
        look(20'h00a01, 0, 1);
        chk(s_dirty == 1, "R5 dirty after write", s_dirty, 1);

        look(20'h00a02, 0, 1);
        chk(s_fault && !s_hit, "R6 user on kernel page", s_fault, 1);
        look(20'h00a02, 0, 0);
        chk(s_hit && s_refd == 0, "R6 no flag change on fault", s_refd, 0);

        look(20'h00a03, 1, 1);
        chk(s_fault && !s_hit, "R7 write readonly", s_fault, 1);
        look(20'h00a03, 0, 1);
        chk(s_hit && s_dirty == 0 && s_refd == 0, "R7 flags untouched", s_dirty, 0);

        cyc(0, '0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 1);
        look(20'h00a01, 0, 1);
        chk(s_refd == 0, "R8 bulk clear", s_refd, 0);

        // R13: clear wins over same-cycle reference
        cyc(1, 20'h00a04, 12'h001, 0, 1, 0, '0, '0, 0, 0, 0, 1);
        look(20'h00a04, 0, 1);
        chk(s_refd == 0, "R13 clear over ref", s_refd, 0);
        // R13: lookup does not see same-cycle refill
        cyc(1, 20'h00a05, 12'h002, 0, 1, 1, 20'h00a05, 20'h55555, 0, 1, 0, 0);
        chk(!s_hit, "R13 refill not visible", s_hit, 0);
        look(20'h00a05, 0, 1);
        chk(s_hit && s_paddr[PA_W-1:PAGE_BITS] == 20'h55555, "R9 refill visible next", s_paddr, 20'h55555);

        for (int i = 5; i < ENTRIES; i++) fill(20'h00b00 + 20'(i), 20'h60000 + 20'(i), 0, 1);
        look(20'h00b0f, 0, 1);
        chk(s_hit, "R2 last slot", s_hit, 1);
        // full table: first refill hits slot 0 (dirty page a01)
        fill(20'h00c01, 20'h70001, 0, 1);
        chk(s_wb && s_wbvpn == 20'h00a01, "R11 dirty eviction", s_wbvpn, 20'h00a01);
        look(20'h00a01, 0, 1);
        chk(!s_hit && !s_fault, "R9 first filled evicted", s_hit, 0);
        fill(20'h00c02, 20'h70002, 0, 1);
        chk(!s_wb, "R11 clean eviction silent", s_wb, 0);
        look(20'h00a02, 0, 0);
        chk(!s_hit, "R10 pointer advanced", s_hit, 0);
        look(20'h00a03, 0, 1);
        chk(s_hit, "R10 slot 2 kept", s_hit, 1);

        // flush with dropped refill
        cyc(0, '0, '0, 0, 0, 1, 20'h00d01, 20'h7abcd, 0, 1, 1, 0);
        look(20'h00d01, 0, 1);
        chk(!s_hit, "R12 refill dropped", s_hit, 0);
        look(20'h00c01, 0, 1);
        chk(!s_hit, "R12 all invalid", s_hit, 0);

        // random phase against the model
        seed = 32'h1badcafe;
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [VPN_W-1:0] v;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            op = (seed >>> 3) & 15;
            v  = 20'h00200 + 20'(((seed >>> 8) & 32'h7fffffff) % 24);
            if (op < 7)
                cyc(1, v, 12'(seed), op[0], op[1], 0, '0, '0, 0, 0, 0, 0);
            else if (op < 12 && !resident(v))
                cyc(op[0], v ^ 20'h1, 12'(seed), op[1], 1, 1, v, 20'(seed >>> 4), op[2], op[3] | op[1], 0, 0);
            else if (op == 12)
                cyc(1, v, 12'(seed), 0, 0, 0, '0, '0, 0, 0, 0, 1);
            else if (op == 13 && ((seed >>> 20) & 7) == 0)
                cyc(0, '0, '0, 0, 0, 0, '0, '0, 0, 0, 1, 0);
            else
                cyc(1, v, 12'(seed), 1, 0, 0, '0, '0, 0, 0, 0, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule